// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block tracks the coherence state of every line in a small private cache of one core. Each line is addressed by an index and is always in one of four states: Modified, Exclusive, Shared or Invalid. The core presents read, write and flush requests. The block completes them at once when the line's state allows it. Otherwise it starts exactly one bus transaction and completes the request when that transaction finishes. The four transaction kinds are fetch, fetch-for-ownership, invalidate and write-back.

Snooped transactions from other caches arrive on a separate port and take priority over the core. Snoops that hit an Exclusive or Shared line change the state in the same cycle. A snooped read or fetch-for-ownership that hits a Modified line is deferred: the block writes the line back first and releases the snoop only when the write-back completes. Data storage, tag matching, replacement and bus arbitration sit outside the block and appear only as handshake signals.

The sequencer has three named states. SQ_IDLE accepts snoops and local requests. SQ_LOCAL holds a local bus transaction until `bus_done`. SQ_SNPWB holds the write-back of a deferred snoop. It has five transitions:
- SQ_IDLE to SQ_LOCAL on a local miss, an upgrade or a flush of a Modified line.
- SQ_IDLE to SQ_SNPWB when a snoop hits a Modified line.
- SQ_LOCAL to SQ_IDLE on `bus_done`.
- SQ_SNPWB to SQ_IDLE on `bus_done`.
- SQ_IDLE to SQ_IDLE for every request or snoop that completes without the bus.

Top module: `mesi_line_ctrl`

## Requirements
- R1: Line state encoding is Invalid=00, Shared=01, Exclusive=10, Modified=11. After reset every line is Invalid. `req_state` shows the state of the line at `req_idx`.
- R2: A read (`req_op`=00) of a line in Modified, Exclusive or Shared asserts `req_done` and `req_hit` in the same cycle, issues no bus transaction and leaves the state unchanged.
- R3: A read of an Invalid line issues a fetch (`bus_op`=001). On `bus_done` the line becomes Exclusive if `bus_shared_in` is low, or Shared if it is high, and `req_done` is asserted.
- R4: A write (`req_op`=01) to a Modified or Exclusive line completes with `req_hit` in the request cycle and no bus traffic. An Exclusive line becomes Modified.
- R5: A write to a Shared line first issues an invalidate (`bus_op`=011). The line becomes Modified only when that invalidate completes.
- R6: A write to an Invalid line issues a fetch-for-ownership (`bus_op`=010). The line becomes Modified when the fill completes.
- R7: A snooped read (`snp_op`=00) or fetch-for-ownership (`snp_op`=01) that hits a Modified line asserts `snp_defer` and issues a write-back (`bus_op`=100). On its completion `snp_done` rises and the line becomes Shared (for a read) or Invalid (for fetch-for-ownership).
- R8: A snooped read of an Exclusive line moves it to Shared. A snooped read of a Shared line leaves it Shared. Either completes with `snp_done` in the same cycle. `snp_shared` is high whenever the snooped line is not Invalid.
- R9: A snooped invalidate (`snp_op`=10) or fetch-for-ownership of a Shared or Exclusive line moves it to Invalid in the same cycle, with no bus traffic.
- R10: A flush (`req_op`=10) of a Modified line issues a write-back and leaves the line Exclusive. A flush of any other line completes at once with no bus traffic and no state change.
- R11: A Shared line is never promoted to Exclusive, even after snoops on other lines or further local reads.
- R12: Only one bus transaction is outstanding, and `bus_op` and `bus_idx` hold steady until `bus_done`. A snoop in the same cycle as a local request is served first while `req_stall` is high. A snoop arriving during a local transaction waits, with `snp_done` low, until that transaction ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present, held until `req_done` |
| req_op | input | 2 | 00 read, 01 write, 10 flush |
| req_idx | input | IDX_W | Line index of local request |
| req_done | output | 1 | Local request completes this cycle |
| req_hit | output | 1 | Completion without a bus transaction |
| req_stall | output | 1 | Request present but not completing |
| req_state | output | 2 | State of the line at `req_idx` |
| bus_valid | output | 1 | Bus transaction outstanding |
| bus_op | output | 3 | 001 fetch, 010 fetch-for-ownership, 011 invalidate, 100 write-back |
| bus_idx | output | IDX_W | Line index of bus transaction |
| bus_done | input | 1 | Bus transaction finishes this cycle |
| bus_shared_in | input | 1 | Another cache holds the line, sampled with `bus_done` of a fetch |
| snp_valid | input | 1 | Snooped transaction present, held until `snp_done` |
| snp_op | input | 2 | 00 read, 01 fetch-for-ownership, 10 invalidate |
| snp_idx | input | IDX_W | Line index of the snoop |
| snp_defer | output | 1 | Snoop held off pending write-back |
| snp_shared | output | 1 | This cache holds a copy of the snooped line |
| snp_done | output | 1 | Snoop answered or released this cycle |

## Verification
A wrong stored state shows up at `req_state` in the cycle after the faulty update. It also changes behaviour at the next access to that line. A line wrongly held as Exclusive lets a write complete with `req_hit` where an invalidate on `bus_op` was due. A line wrongly held as Modified turns a plain snoop into a deferred write-back. A sequencer left in the wrong state is visible within one cycle: `bus_valid` stays high or drops early, `snp_defer` hangs, or `req_stall` stays asserted after `bus_done`.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_st_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'b00,
        SQ_LOCAL = 2'b01,
        SQ_SNPWB = 2'b10
    } seq_st_t;

    localparam logic [1:0] RQ_READ  = 2'b00;
    localparam logic [1:0] RQ_WRITE = 2'b01;
    localparam logic [1:0] RQ_FLUSH = 2'b10;

    localparam logic [1:0] SN_READ  = 2'b00;
    localparam logic [1:0] SN_RDX   = 2'b01;
    localparam logic [1:0] SN_INV   = 2'b10;

    localparam logic [2:0] BO_NONE  = 3'b000;
    localparam logic [2:0] BO_RD    = 3'b001;
    localparam logic [2:0] BO_RDX   = 3'b010;
    localparam logic [2:0] BO_INV   = 3'b011;
    localparam logic [2:0] BO_WB    = 3'b100;

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  line_st_t                         wr_st,
    input  logic [IDX_W-1:0]                 rd_a_idx,
    output line_st_t                         rd_a_st,
    input  logic [IDX_W-1:0]                 rd_b_idx,
    output line_st_t                         rd_b_st,
    output logic [NUM_LINES-1:0][1:0]        st_all
);

    line_st_t st_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[g] <= ST_I;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                st_q[g] <= wr_st;
            end
        end

        assign st_all[g] = st_q[g];
    end

    assign rd_a_st = st_q[rd_a_idx];
    assign rd_b_st = st_q[rd_b_idx];

endmodule

// File: rtl/mesi_seq.sv
module mesi_seq
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    input  line_st_t         req_line_st,
    input  logic             snp_valid,
    input  logic [1:0]       snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    input  line_st_t         snp_line_st,
    input  logic             bus_done,
    input  logic             bus_shared_in,
    output logic             req_done,
    output logic             req_hit,
    output logic             req_stall,
    output logic             bus_valid,
    output logic [2:0]       bus_op,
    output logic [IDX_W-1:0] bus_idx,
    output logic             snp_defer,
    output logic             snp_shared,
    output logic             snp_done,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output line_st_t         wr_st
);

    seq_st_t          fsm_q, fsm_d;
    logic [2:0]       op_q, op_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    line_st_t         fin_q, fin_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= SQ_IDLE;
            op_q  <= BO_NONE;
            idx_q <= '0;
            fin_q <= ST_I;
        end else begin
            fsm_q <= fsm_d;
            op_q  <= op_d;
            idx_q <= idx_d;
            fin_q <= fin_d;
        end
    end

    // outputs and next state
    always_comb begin
        fsm_d      = fsm_q;
        op_d       = op_q;
        idx_d      = idx_q;
        fin_d      = fin_q;
        req_done   = 1'b0;
        req_hit    = 1'b0;
        bus_valid  = 1'b0;
        bus_op     = BO_NONE;
        bus_idx    = idx_q;
        snp_defer  = 1'b0;
        snp_shared = 1'b0;
        snp_done   = 1'b0;
        wr_en      = 1'b0;
        wr_idx     = idx_q;
        wr_st      = ST_I;

        unique case (fsm_q)
            SQ_IDLE: begin
                if (snp_valid) begin
                    snp_shared = (snp_line_st != ST_I);
                    wr_idx     = snp_idx;
                    if ((snp_line_st == ST_M) && (snp_op != SN_INV)) begin
                        snp_defer = 1'b1;
                        fsm_d     = SQ_SNPWB;
                        op_d      = BO_WB;
                        idx_d     = snp_idx;
                        fin_d     = (snp_op == SN_READ) ? ST_S : ST_I;
                    end else begin
                        snp_done = 1'b1;
                        if (snp_op == SN_READ) begin
                            wr_en = (snp_line_st == ST_E);
                            wr_st = ST_S;
                        end else begin
                            wr_en = (snp_line_st != ST_I);
                            wr_st = ST_I;
                        end
                    end
                end else if (req_valid) begin
                    wr_idx = req_idx;
                    case (req_op)
                        RQ_READ: begin
                            if (req_line_st != ST_I) begin
                                req_done = 1'b1;
                                req_hit  = 1'b1;
                            end else begin
                                fsm_d = SQ_LOCAL;
                                op_d  = BO_RD;
                                idx_d = req_idx;
                            end
                        end
                        RQ_WRITE: begin
                            if ((req_line_st == ST_M) || (req_line_st == ST_E)) begin
                                req_done = 1'b1;
                                req_hit  = 1'b1;
                                wr_en    = (req_line_st == ST_E);
                                wr_st    = ST_M;
                            end else begin
                                fsm_d = SQ_LOCAL;
                                op_d  = (req_line_st == ST_S) ? BO_INV : BO_RDX;
                                idx_d = req_idx;
                            end
                        end
                        RQ_FLUSH: begin
                            if (req_line_st == ST_M) begin
                                fsm_d = SQ_LOCAL;
                                op_d  = BO_WB;
                                idx_d = req_idx;
                            end else begin
                                req_done = 1'b1;
                                req_hit  = 1'b1;
                            end
                        end
                        default: begin
                            req_done = 1'b1;
                        end
                    endcase
                end
            end
            SQ_LOCAL: begin
                bus_valid = 1'b1;
                bus_op    = op_q;
                if (bus_done) begin
                    req_done = 1'b1;
                    wr_en    = 1'b1;
                    fsm_d    = SQ_IDLE;
                    unique case (op_q)
                        BO_RD:   wr_st = bus_shared_in ? ST_S : ST_E;
                        BO_WB:   wr_st = ST_E;
                        default: wr_st = ST_M;
                    endcase
                end
            end
            SQ_SNPWB: begin
                bus_valid  = 1'b1;
                bus_op     = BO_WB;
                snp_shared = 1'b1;
                snp_defer  = !bus_done;
                if (bus_done) begin
                    snp_done = 1'b1;
                    wr_en    = 1'b1;
                    wr_st    = fin_q;
                    fsm_d    = SQ_IDLE;
                end
            end
            default: begin
                fsm_d = SQ_IDLE;
            end
        endcase

        req_stall = req_valid && !req_done;
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    output logic             req_done,
    output logic             req_hit,
    output logic             req_stall,
    output logic [1:0]       req_state,
    output logic             bus_valid,
    output logic [2:0]       bus_op,
    output logic [IDX_W-1:0] bus_idx,
    input  logic             bus_done,
    input  logic             bus_shared_in,
    input  logic             snp_valid,
    input  logic [1:0]       snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_defer,
    output logic             snp_shared,
    output logic             snp_done
);

    line_st_t                  req_line_st;
    line_st_t                  snp_line_st;
    logic                      wr_en;
    logic [IDX_W-1:0]          wr_idx;
    line_st_t                  wr_st;
    logic [NUM_LINES-1:0][1:0] st_all;

    mesi_state_array #(.NUM_LINES(NUM_LINES)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_st    (wr_st),
        .rd_a_idx (req_idx),
        .rd_a_st  (req_line_st),
        .rd_b_idx (snp_idx),
        .rd_b_st  (snp_line_st),
        .st_all   (st_all)
    );

    mesi_seq #(.NUM_LINES(NUM_LINES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_idx       (req_idx),
        .req_line_st   (req_line_st),
        .snp_valid     (snp_valid),
        .snp_op        (snp_op),
        .snp_idx       (snp_idx),
        .snp_line_st   (snp_line_st),
        .bus_done      (bus_done),
        .bus_shared_in (bus_shared_in),
        .req_done      (req_done),
        .req_hit       (req_hit),
        .req_stall     (req_stall),
        .bus_valid     (bus_valid),
        .bus_op        (bus_op),
        .bus_idx       (bus_idx),
        .snp_defer     (snp_defer),
        .snp_shared    (snp_shared),
        .snp_done      (snp_done),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_st         (wr_st)
    );

    assign req_state = req_line_st;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_done,
    input logic                      req_hit,
    input logic [1:0]                req_op,
    input logic                      bus_valid,
    input logic [2:0]                bus_op,
    input logic [IDX_W-1:0]          bus_idx,
    input logic                      bus_done,
    input logic                      bus_shared_in,
    input logic                      snp_done,
    input logic                      snp_defer,
    input logic [1:0]                snp_op,
    input logic [IDX_W-1:0]          snp_idx,
    input logic [NUM_LINES-1:0][1:0] st_all
);

    // R3: fetch fill lands in Exclusive or Shared per the shared input
    assert_fill_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_done && bus_op == BO_RD) |=>
        (st_all[$past(bus_idx)] == ($past(bus_shared_in) ? ST_S : ST_E)));

    // R4 R5 R6: every completed write leaves the line Modified
    assert_write_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && req_op == RQ_WRITE) |=> (st_all[$past(bus_idx)] == ST_M)
                                             || !$past(bus_valid));

    // R5: a write without bus traffic only completes as a hit
    assert_write_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && req_op == RQ_WRITE && !bus_valid) |-> req_hit);

    // R7: a held deferral is always backed by a write-back on the bus
    assert_defer_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_defer && $past(snp_defer)) |-> (bus_valid && bus_op == BO_WB));

    // R8: a snooped read of a held line leaves it Shared
    assert_snoop_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_done && snp_op == SN_READ && st_all[snp_idx] != ST_I) |=>
        (st_all[$past(snp_idx)] == ST_S));

    // R9: an ownership-taking snoop leaves the line Invalid
    assert_snoop_kill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_done && snp_op != SN_READ) |=> (st_all[$past(snp_idx)] == ST_I));

    // R10: a voluntary write-back leaves the line Exclusive
    assert_flush_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && req_op == RQ_FLUSH && bus_valid) |=>
        (st_all[$past(bus_idx)] == ST_E));

    // R12: the outstanding transaction is stable until it completes
    assert_one_txn_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_op) && $stable(bus_idx)));

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_done      (req_done),
    .req_hit       (req_hit),
    .req_op        (req_op),
    .bus_valid     (bus_valid),
    .bus_op        (bus_op),
    .bus_idx       (bus_idx),
    .bus_done      (bus_done),
    .bus_shared_in (bus_shared_in),
    .snp_done      (snp_done),
    .snp_defer     (snp_defer),
    .snp_op        (snp_op),
    .snp_idx       (snp_idx),
    .st_all        (st_all)
);

// File: tb/mesi_line_ctrl_bench.sv
module mesi_line_ctrl_bench;

    localparam int CLK_T     = 10;
    localparam int NUM_LINES = 8;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int NV        = 20;

    // kind: 0 read, 1 write, 2 flush, 3 snoop read, 4 snoop rdx, 5 snoop inv
    function automatic logic [15:0] mk(input int kind, input int idx, input bit shr,
                                       input int bop, input bit hit, input bit dfr,
                                       input int st);
        return {kind[2:0], idx[2:0], shr, bop[2:0], hit, dfr, st[1:0], 2'b00};
    endfunction

    // state: 0 I, 1 S, 2 E, 3 M ; bus: 0 none, 1 fetch, 2 rdx, 3 inv, 4 wb
    localparam logic [15:0] VEC [NV] = '{
        mk(0, 0, 0, 1, 0, 0, 2),  // R3 read miss, fills Exclusive
        mk(0, 0, 0, 0, 1, 0, 2),  // R2 read hit E
        mk(1, 0, 0, 0, 1, 0, 3),  // R4 write E -> M
        mk(1, 0, 0, 0, 1, 0, 3),  // R4 write M
        mk(3, 0, 0, 4, 1, 1, 1),  // R7 snoop read M deferred -> S
        mk(0, 0, 0, 0, 1, 0, 1),  // R2 read hit S
        mk(1, 0, 0, 3, 0, 0, 3),  // R5 write S -> invalidate -> M
        mk(2, 0, 0, 4, 0, 0, 2),  // R10 flush M -> E
        mk(3, 0, 0, 0, 1, 0, 1),  // R8 snoop read E -> S
        mk(5, 0, 0, 0, 1, 0, 0),  // R9 snoop inv S -> I
        mk(0, 1, 1, 1, 0, 0, 1),  // R3 read miss shared -> S
        mk(4, 1, 0, 0, 1, 0, 0),  // R9 snoop rdx S -> I
        mk(1, 2, 0, 2, 0, 0, 3),  // R6 write miss -> rdx -> M
        mk(4, 2, 0, 4, 1, 1, 0),  // R7 snoop rdx M deferred -> I
        mk(2, 3, 0, 0, 1, 0, 0),  // R10 flush I no bus
        mk(0, 4, 1, 1, 0, 0, 1),  // R3 fill shared
        mk(5, 5, 0, 0, 0, 0, 0),  // R8 snoop on I: no copy
        mk(0, 4, 0, 0, 1, 0, 1),  // R11 stays Shared
        mk(0, 6, 0, 1, 0, 0, 2),  // R3 fill Exclusive
        mk(3, 6, 0, 0, 1, 0, 1)   // R8 snoop read E -> S
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_op = '0;
    logic [IDX_W-1:0] req_idx = '0;
    logic             req_done, req_hit, req_stall;
    logic [1:0]       req_state;
    logic             bus_valid;
    logic [2:0]       bus_op;
    logic [IDX_W-1:0] bus_idx;
    logic             bus_done = 1'b0;
    logic             bus_shared_in = 1'b0;
    logic             snp_valid = 1'b0;
    logic [1:0]       snp_op = '0;
    logic [IDX_W-1:0] snp_idx = '0;
    logic             snp_defer, snp_shared, snp_done;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_T/2) clk = ~clk;

    mesi_line_ctrl #(.NUM_LINES(NUM_LINES)) u_mesi_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
        .req_done(req_done), .req_hit(req_hit), .req_stall(req_stall),
        .req_state(req_state),
        .bus_valid(bus_valid), .bus_op(bus_op), .bus_idx(bus_idx),
        .bus_done(bus_done), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_idx(snp_idx),
        .snp_defer(snp_defer), .snp_shared(snp_shared), .snp_done(snp_done)
    );

    task automatic check(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic run_op(input int kind, input int idx, input bit shr,
                          output int bus_seen, output int hit_seen, output int dfr_seen,
                          output int done_seen, output int st_seen);
        @(negedge clk);
        bus_seen = 0;
        dfr_seen = 0;
        if (kind < 3) begin
            req_valid = 1'b1;
            req_op    = kind[1:0];
            req_idx   = idx[IDX_W-1:0];
            #1;
            hit_seen  = int'(req_done && req_hit);
            done_seen = int'(req_done);
            if (!req_done) begin
                @(negedge clk);
                bus_seen      = bus_valid ? int'(bus_op) : 0;
                bus_done      = 1'b1;
                bus_shared_in = shr;
                #1;
                done_seen = int'(req_done);
            end
        end else begin
            snp_valid = 1'b1;
            snp_op    = 2'(kind - 3);
            snp_idx   = idx[IDX_W-1:0];
            #1;
            hit_seen  = int'(snp_shared);
            dfr_seen  = int'(snp_defer);
            done_seen = int'(snp_done);
            if (snp_defer) begin
                @(negedge clk);
                bus_seen = bus_valid ? int'(bus_op) : 0;
                bus_done = 1'b1;
                #1;
                done_seen = int'(snp_done);
            end
        end
        @(negedge clk);
        req_valid     = 1'b0;
        snp_valid     = 1'b0;
        bus_done      = 1'b0;
        bus_shared_in = 1'b0;
        req_idx       = idx[IDX_W-1:0];
        #1;
        st_seen = int'(req_state);
    endtask

    initial begin
        int wd = 0;
        while (wd < 50000) begin
            @(posedge clk);
            wd++;
        end
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int b, h, d, dn, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every line Invalid after reset
        for (int i = 0; i < NUM_LINES; i++) begin
            req_idx = i[IDX_W-1:0];
            #1;
            check("R1", "reset state", int'(req_state), 0);
        end
        check("R12", "idle bus", int'(bus_valid), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            int kind, idx;
            kind = int'(VEC[i][15:13]);
            idx  = int'(VEC[i][12:10]);
            run_op(kind, idx, VEC[i][9], b, h, d, dn, s);
            check(kind < 3 ? "R2/R3/R4/R5/R6/R10 vec" : "R7/R8/R9 vec", $sformatf("bus op v%0d", i), b, int'(VEC[i][8:6]));
            check("R2_R8 hit/shared", $sformatf("v%0d", i), h, int'(VEC[i][5]));
            check("R7 defer", $sformatf("v%0d", i), d, int'(VEC[i][4]));
            check("R12 completion", $sformatf("v%0d", i), dn, 1);
            check("R1 final state", $sformatf("v%0d", i), s, int'(VEC[i][3:2]));
        end

        // R12: snoop and local request in the same cycle; line 0 is Invalid, line 7 Invalid
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b00; req_idx = 3'd7;
        snp_valid = 1'b1; snp_op = 2'b00; snp_idx = 3'd0;
        #1;
        check("R12", "stall on collision", int'(req_stall), 1);
        check("R12", "no req done on collision", int'(req_done), 0);
        check("R12", "snoop served first", int'(snp_done), 1);
        @(negedge clk);
        snp_valid = 1'b0;
        @(negedge clk);
        check("R12", "fetch after snoop", int'(bus_valid ? bus_op : 3'd0), 1);
        check("R12", "fetch index", int'(bus_idx), 7);
        bus_done = 1'b1;
        #1;
        check("R3", "fill done", int'(req_done), 1);
        @(negedge clk);
        req_valid = 1'b0; bus_done = 1'b0;
        #1;
        check("R3", "line 7 Exclusive", int'(req_state), 2);

        // R12: snoop during local transaction waits
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b01; req_idx = 3'd3;
        @(negedge clk);
        snp_valid = 1'b1; snp_op = 2'b00; snp_idx = 3'd4;
        #1;
        check("R6", "rdx issued", int'(bus_op), 2);
        check("R12", "snoop waits", int'(snp_done), 0);
        @(negedge clk);
        check("R12", "op held", int'(bus_op), 2);
        check("R12", "snoop still waits", int'(snp_done), 0);
        bus_done = 1'b1;
        #1;
        check("R6", "write done", int'(req_done), 1);
        @(negedge clk);
        bus_done = 1'b0; req_valid = 1'b0;
        #1;
        check("R12", "snoop after txn", int'(snp_done), 1);
        check("R11", "shared copy reported", int'(snp_shared), 1);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        check("R6", "line 3 Modified", int'(req_state), 3);
        req_idx = 3'd4;
        #1;
        check("R11", "line 4 still Shared", int'(req_state), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule